// File: doc/BRIEF.md
# Split-Transaction Outstanding Request Table

This block keeps track of bus transactions that are still waiting for their data in a bus interface that separates the request phase from the response phase. Every cache controller on the bus holds an identical copy. When a request wins the address bus and no snooper refuses it, every copy writes it into the same slot at the same time. That slot is the lowest free index, and its number is the tag that the later response will carry. A slot holds the block address, the kind of request, and the snoop state this cache reported for it once that state is known.

Each new bus request is compared against every live slot at once. A request to a block that already has a live transaction is flagged as a conflict and is not recorded, so the controller can refuse it or retry it. A second lookup port lets the processor side ask whether its own address is in flight, and returns that slot's tag, kind and snoop state. A response on the data bus releases the slot named by its tag, and that tag can then be handed out again. While every slot is live, the table asks the arbiter to hold off new requests.

Top module: `split_req_table`

## Requirements
- R1: After reset no slot is live, `live_count` is 0, `table_empty` is 1, `arb_hold` is 0, `bus_req_tag` is 0 and `cpu_hit` is 0.
- R2: A request with `bus_req_valid`=1, `bus_req_nack`=0, no conflict and a free slot raises `bus_req_accept` in the same cycle. From the next cycle on, its address and kind (0 shared read, 1 exclusive read, 2 upgrade, 3 writeback) are visible through the processor lookup.
- R3: `bus_req_tag` always shows the lowest-numbered free slot, and an accepted request is stored in that slot.
- R4: When `bus_req_addr` equals the address of a live slot, `bus_req_conflict` is 1 in the same cycle, `bus_req_accept` is 0 and nothing is recorded.
- R5: A request with `bus_req_nack`=1 is not recorded and `live_count` does not change.
- R6: While all NUM_TAGS slots are live, `arb_hold` is 1 and a request is neither accepted nor recorded.
- R7: `rsp_valid` with `rsp_tag` naming a live slot frees that slot from the next cycle on. A response naming a free slot has no effect.
- R8: A new slot reads snoop-known 0 and snoop state 0. `snp_upd_valid` on a live slot sets known to 1 and stores `snp_upd_state` (0 invalid, 1 shared, 2 exclusive, 3 modified) from the next cycle on. An update to a free slot has no effect on a later occupant of that slot.
- R9: `cpu_hit` is 1 in the same cycle that `cpu_addr` equals a live slot's address, with that slot's tag, kind and snoop fields. Otherwise all of these read 0.
- R10: `live_count` equals the number of live slots, and `table_empty` is 1 exactly when it is 0.
- R11: A response and a new request in the same cycle both take effect. The freed slot still counts as live for that cycle's conflict check and free-slot choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_valid | input | 1 | A request holds the address bus this cycle |
| bus_req_addr | input | ADDR_W | Block address of that request |
| bus_req_kind | input | 2 | Request kind |
| bus_req_nack | input | 1 | A snooper refused the request |
| bus_req_conflict | output | 1 | Address matches a live slot |
| bus_req_accept | output | 1 | Request is recorded this cycle |
| bus_req_tag | output | TAG_W | Lowest free slot, the tag given to an accepted request |
| arb_hold | output | 1 | All slots live, block arbitration |
| snp_upd_valid | input | 1 | Snoop result available |
| snp_upd_tag | input | TAG_W | Slot the snoop result belongs to |
| snp_upd_state | input | 2 | Local snoop state |
| rsp_valid | input | 1 | Tagged response on the data bus |
| rsp_tag | input | TAG_W | Tag carried by the response |
| cpu_addr | input | ADDR_W | Processor-side lookup address |
| cpu_hit | output | 1 | Lookup address is in flight |
| cpu_hit_tag | output | TAG_W | Slot of the hit |
| cpu_hit_kind | output | 2 | Kind stored in that slot |
| cpu_hit_snp_known | output | 1 | Snoop state has been recorded |
| cpu_hit_snp_state | output | 2 | Recorded snoop state |
| live_count | output | TAG_W+1 | Number of live slots |
| table_empty | output | 1 | No live slot |

## Verification
The bench targets a response and a request arriving together. A table that released the slot first would let a conflicting request through, or would give out a tag before its response finished. It checks that a freed tag comes back as the lowest free index, so a plain rotating pointer would hand out the wrong tag. It fills every slot and offers one more request, which a table without the full check would write over a live slot. It sends a snoop update and a response to empty slots and checks that stale state does not appear in the slot's next occupant. It also checks that a refused request leaves the count unchanged.

// File: rtl/rqt_pkg.sv
package rqt_pkg;
    localparam int KIND_W = 2;
    localparam int SNP_W  = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_RD_SHARED = 2'd0,
        KIND_RD_EXCL   = 2'd1,
        KIND_UPGRADE   = 2'd2,
        KIND_WRBACK    = 2'd3
    } req_kind_e;

    typedef enum logic [SNP_W-1:0] {
        SNP_INV  = 2'd0,
        SNP_SHR  = 2'd1,
        SNP_EXC  = 2'd2,
        SNP_MOD  = 2'd3
    } snp_state_e;
endpackage

// File: rtl/rqt_find_free.sv
module rqt_find_free #(
    parameter int N     = 8,
    parameter int TAG_W = $clog2(N)
) (
    input  logic [N-1:0]     live,
    output logic [TAG_W-1:0] free_idx,
    output logic             any_free
);
    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!live[i]) free_idx = TAG_W'(i);
        end
        any_free = ~&live;
    end
endmodule

// File: rtl/rqt_match.sv
module rqt_match #(
    parameter int N      = 8,
    parameter int ADDR_W = 32
) (
    input  logic [N-1:0]             live,
    input  logic [N-1:0][ADDR_W-1:0] addrs,
    input  logic [ADDR_W-1:0]        key,
    output logic [N-1:0]             hit_vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = live[g] && (addrs[g] == key);
    end
endmodule

// File: rtl/rqt_entry.sv
module rqt_entry
    import rqt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  req_kind_e         alloc_kind,
    input  logic              snp_en,
    input  snp_state_e        snp_state,
    input  logic              free_en,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output req_kind_e         kind,
    output logic              snp_known,
    output snp_state_e        snp_val
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        req_kind_e         kind;
        logic              known;
        snp_state_e        snp;
    } ent_t;

    ent_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (free_en) begin
            ent_d.valid = 1'b0;
            ent_d.known = 1'b0;
            ent_d.snp   = SNP_INV;
        end else if (alloc_en) begin
            ent_d.valid = 1'b1;
            ent_d.addr  = alloc_addr;
            ent_d.kind  = alloc_kind;
            ent_d.known = 1'b0;
            ent_d.snp   = SNP_INV;
        end else if (snp_en) begin
            ent_d.known = 1'b1;
            ent_d.snp   = snp_state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '{valid: 1'b0, addr: '0, kind: KIND_RD_SHARED,
                       known: 1'b0, snp: SNP_INV};
        end else begin
            ent_q <= ent_d;
        end
    end

    assign valid     = ent_q.valid;
    assign addr      = ent_q.addr;
    assign kind      = ent_q.kind;
    assign snp_known = ent_q.known;
    assign snp_val   = ent_q.snp;

    // R3: a slot is only ever written while it is free
    p_alloc_into_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !ent_q.valid);

    // R2: an allocation leaves the slot live with the offered address
    p_alloc_records_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en && !free_en |=> ent_q.valid && ent_q.addr == $past(alloc_addr));
endmodule

// File: rtl/split_req_table.sv
module split_req_table
    import rqt_pkg::*;
#(
    parameter int NUM_TAGS = 8,
    parameter int ADDR_W   = 32,
    localparam int TAG_W   = $clog2(NUM_TAGS),
    localparam int CNT_W   = TAG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req_valid,
    input  logic [ADDR_W-1:0] bus_req_addr,
    input  logic [1:0]        bus_req_kind,
    input  logic              bus_req_nack,
    output logic              bus_req_conflict,
    output logic              bus_req_accept,
    output logic [TAG_W-1:0]  bus_req_tag,
    output logic              arb_hold,
    input  logic              snp_upd_valid,
    input  logic [TAG_W-1:0]  snp_upd_tag,
    input  logic [1:0]        snp_upd_state,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_hit,
    output logic [TAG_W-1:0]  cpu_hit_tag,
    output logic [1:0]        cpu_hit_kind,
    output logic              cpu_hit_snp_known,
    output logic [1:0]        cpu_hit_snp_state,
    output logic [CNT_W-1:0]  live_count,
    output logic              table_empty
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_TAGS-1:0]             live_vec;
    logic [NUM_TAGS-1:0][ADDR_W-1:0] addr_vec;
    req_kind_e                       kind_vec  [NUM_TAGS];
    logic [NUM_TAGS-1:0]             known_vec;
    snp_state_e                      snp_vec   [NUM_TAGS];

    logic [NUM_TAGS-1:0] bus_hit_vec, cpu_hit_vec;
    logic [NUM_TAGS-1:0] alloc_vec, free_vec, snpw_vec;
    logic [TAG_W-1:0]    free_idx;
    logic                any_free;
    logic                alloc;

    rqt_find_free #(.N(NUM_TAGS), .TAG_W(TAG_W)) u_free (
        .live     (live_vec),
        .free_idx (free_idx),
        .any_free (any_free)
    );

    rqt_match #(.N(NUM_TAGS), .ADDR_W(ADDR_W)) u_bus_match (
        .live    (live_vec),
        .addrs   (addr_vec),
        .key     (bus_req_addr),
        .hit_vec (bus_hit_vec)
    );

    rqt_match #(.N(NUM_TAGS), .ADDR_W(ADDR_W)) u_cpu_match (
        .live    (live_vec),
        .addrs   (addr_vec),
        .key     (cpu_addr),
        .hit_vec (cpu_hit_vec)
    );

    assign bus_req_conflict = |bus_hit_vec;
    assign alloc            = bus_req_valid && !bus_req_nack && !bus_req_conflict && any_free;
    assign bus_req_accept   = alloc;
    assign bus_req_tag      = free_idx;
    assign arb_hold         = !any_free;

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
        assign alloc_vec[g] = alloc && (free_idx == TAG_W'(g));
        assign free_vec[g]  = rsp_valid && (rsp_tag == TAG_W'(g)) && live_vec[g];
        assign snpw_vec[g]  = snp_upd_valid && (snp_upd_tag == TAG_W'(g)) && live_vec[g];

        rqt_entry #(.ADDR_W(ADDR_W)) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_en   (alloc_vec[g]),
            .alloc_addr (bus_req_addr),
            .alloc_kind (req_kind_e'(bus_req_kind)),
            .snp_en     (snpw_vec[g]),
            .snp_state  (snp_state_e'(snp_upd_state)),
            .free_en    (free_vec[g]),
            .valid      (live_vec[g]),
            .addr       (addr_vec[g]),
            .kind       (kind_vec[g]),
            .snp_known  (known_vec[g]),
            .snp_val    (snp_vec[g])
        );
    end

    always_comb begin
        cpu_hit           = 1'b0;
        cpu_hit_tag       = '0;
        cpu_hit_kind      = '0;
        cpu_hit_snp_known = 1'b0;
        cpu_hit_snp_state = '0;
        for (int i = 0; i < NUM_TAGS; i++) begin
            if (cpu_hit_vec[i]) begin
                cpu_hit           = 1'b1;
                cpu_hit_tag       = TAG_W'(i);
                cpu_hit_kind      = kind_vec[i];
                cpu_hit_snp_known = known_vec[i];
                cpu_hit_snp_state = snp_vec[i];
            end
        end
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.count = ctl_q.count + CNT_W'(alloc) - CNT_W'(|free_vec);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign live_count  = ctl_q.count;
    assign table_empty = (ctl_q.count == '0);

    // R10: the separately kept count agrees with the live slots
    p_count_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        live_count == CNT_W'($countones(live_vec)));

    // R4: refused duplicates keep each address in at most one slot
    p_single_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_hit_vec) && $onehot0(bus_hit_vec));

    // R6: nothing is accepted while every slot is live
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        live_count == CNT_W'(NUM_TAGS) |-> !bus_req_accept);

    // R7: a response to a live slot releases it on the next cycle
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && live_vec[rsp_tag] |=> !live_vec[$past(rsp_tag)]);
endmodule

// File: tb/tb_split_req_table.sv
module tb_split_req_table;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 8;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req_valid = 1'b0;
    logic [AW-1:0] bus_req_addr = '0;
    logic [1:0] bus_req_kind = '0;
    logic bus_req_nack = 1'b0;
    logic bus_req_conflict, bus_req_accept, arb_hold;
    logic [2:0] bus_req_tag;
    logic snp_upd_valid = 1'b0;
    logic [2:0] snp_upd_tag = '0;
    logic [1:0] snp_upd_state = '0;
    logic rsp_valid = 1'b0;
    logic [2:0] rsp_tag = '0;
    logic [AW-1:0] cpu_addr = '0;
    logic cpu_hit, cpu_hit_snp_known;
    logic [2:0] cpu_hit_tag;
    logic [1:0] cpu_hit_kind, cpu_hit_snp_state;
    logic [3:0] live_count;
    logic table_empty;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_req_table #(.NUM_TAGS(NT), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req_valid(bus_req_valid), .bus_req_addr(bus_req_addr),
        .bus_req_kind(bus_req_kind), .bus_req_nack(bus_req_nack),
        .bus_req_conflict(bus_req_conflict), .bus_req_accept(bus_req_accept),
        .bus_req_tag(bus_req_tag), .arb_hold(arb_hold),
        .snp_upd_valid(snp_upd_valid), .snp_upd_tag(snp_upd_tag),
        .snp_upd_state(snp_upd_state),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
        .cpu_addr(cpu_addr), .cpu_hit(cpu_hit), .cpu_hit_tag(cpu_hit_tag),
        .cpu_hit_kind(cpu_hit_kind), .cpu_hit_snp_known(cpu_hit_snp_known),
        .cpu_hit_snp_state(cpu_hit_snp_state),
        .live_count(live_count), .table_empty(table_empty)
    );

    typedef struct packed {
        logic       rv;
        logic [7:0] addr;
        logic [1:0] kind;
        logic       nack;
        logic       sv;
        logic [2:0] stag;
        logic       acc;
        logic [2:0] tag;
        logic       conf;
        logic [3:0] cnt;
    } vec_t;

    // rv addr kind nack | rsp stag | exp acc tag conf cnt
    localparam vec_t VECS [11] = '{
        '{1'b1, 8'h10, 2'd1, 1'b0, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0, 4'd0}, // R2 first request
        '{1'b1, 8'h20, 2'd0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0, 4'd1}, // R3 next index
        '{1'b1, 8'h10, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0, 3'd2, 1'b1, 4'd2}, // R4 same block
        '{1'b1, 8'h30, 2'd0, 1'b1, 1'b0, 3'd0, 1'b0, 3'd2, 1'b0, 4'd2}, // R5 refused
        '{1'b1, 8'h40, 2'd3, 1'b0, 1'b1, 3'd0, 1'b1, 3'd2, 1'b0, 4'd2}, // R11 free 0 + alloc 2
        '{1'b1, 8'h10, 2'd2, 1'b0, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0, 4'd2}, // R7 tag 0 reused
        '{1'b1, 8'h50, 2'd1, 1'b0, 1'b0, 3'd0, 1'b1, 3'd3, 1'b0, 4'd3}, // R3
        '{1'b1, 8'h20, 2'd0, 1'b0, 1'b1, 3'd1, 1'b0, 3'd4, 1'b1, 4'd4}, // R11 freeing slot still conflicts
        '{1'b1, 8'h20, 2'd0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0, 4'd3}, // R7 tag 1 reused
        '{1'b0, 8'h00, 2'd0, 1'b0, 1'b1, 3'd5, 1'b0, 3'd4, 1'b0, 4'd4}, // R7 response to free slot
        '{1'b0, 8'h00, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd4, 1'b0, 4'd4}  // R10 count unchanged
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        bus_req_valid = 1'b0; bus_req_nack = 1'b0;
        rsp_valid = 1'b0; snp_upd_valid = 1'b0;
    endtask

    task automatic request(logic [AW-1:0] a, logic [1:0] k);
        bus_req_valid = 1'b1; bus_req_addr = a; bus_req_kind = k; bus_req_nack = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cpu_addr = 32'h10;
        #1;
        check("R1 count", 32'(live_count), 0);
        check("R1 empty", 32'(table_empty), 1);
        check("R1 hold", 32'(arb_hold), 0);
        check("R1 tag", 32'(bus_req_tag), 0);
        check("R1 cpu_hit", 32'(cpu_hit), 0);
        rst_n = 1'b1;
        step();

        for (int i = 0; i < 11; i++) begin
            bus_req_valid = VECS[i].rv;
            bus_req_addr  = 32'(VECS[i].addr);
            bus_req_kind  = VECS[i].kind;
            bus_req_nack  = VECS[i].nack;
            rsp_valid     = VECS[i].sv;
            rsp_tag       = VECS[i].stag;
            #1;
            check($sformatf("R2 accept row %0d", i), 32'(bus_req_accept), 32'(VECS[i].acc));
            check($sformatf("R3 tag row %0d", i), 32'(bus_req_tag), 32'(VECS[i].tag));
            check($sformatf("R4 conflict row %0d", i), 32'(bus_req_conflict), 32'(VECS[i].conf));
            check($sformatf("R10 count row %0d", i), 32'(live_count), 32'(VECS[i].cnt));
            step();
            idle();
        end

        // R9 lookups: slots 0:0x10/k2 1:0x20/k0 2:0x40/k3 3:0x50/k1
        cpu_addr = 32'h40; #1;
        check("R9 hit", 32'(cpu_hit), 1);
        check("R9 tag", 32'(cpu_hit_tag), 2);
        check("R9 kind", 32'(cpu_hit_kind), 3);
        cpu_addr = 32'h30; #1;
        check("R5 refused address absent", 32'(cpu_hit), 0);
        cpu_addr = 32'h10; #1;
        check("R2 kind recorded", 32'(cpu_hit_kind), 2);
        check("R8 unknown at start", 32'(cpu_hit_snp_known), 0);
        check("R8 state zero at start", 32'(cpu_hit_snp_state), 0);

        // R8 snoop update
        snp_upd_valid = 1'b1; snp_upd_tag = 3'd0; snp_upd_state = 2'd2;
        step();
        snp_upd_valid = 1'b1; snp_upd_tag = 3'd6; snp_upd_state = 2'd3; // free slot
        #1;
        check("R8 known after update", 32'(cpu_hit_snp_known), 1);
        check("R8 state after update", 32'(cpu_hit_snp_state), 2);
        step();
        idle();

        // R6 fill table
        for (int k = 0; k < 4; k++) begin
            request(32'h60 + 32'(k) * 32'h10, 2'd1);
            #1;
            check("R3 fill tag", 32'(bus_req_tag), 32'(4 + k));
            step();
        end
        idle();
        cpu_addr = 32'h80; #1;
        check("R8 stale update not kept", 32'(cpu_hit_snp_known), 0);
        check("R8 slot 6 tag", 32'(cpu_hit_tag), 6);
        check("R6 hold", 32'(arb_hold), 1);
        check("R10 full count", 32'(live_count), 8);
        request(32'hA0, 2'd0); #1;
        check("R6 accept while full", 32'(bus_req_accept), 0);
        step();
        idle();
        cpu_addr = 32'hA0; #1;
        check("R6 not recorded", 32'(cpu_hit), 0);
        check("R6 count held", 32'(live_count), 8);

        // R7 drain
        for (int k = 0; k < NT; k++) begin
            rsp_valid = 1'b1; rsp_tag = 3'(k);
            step();
        end
        idle();
        #1;
        check("R7 drained count", 32'(live_count), 0);
        check("R10 empty flag", 32'(table_empty), 1);
        check("R7 hold released", 32'(arb_hold), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule